// File: doc/BRIEF.md
# Thread Yield Decision Unit

This unit judges a yield request made by the hardware thread context that is running now. A request brings a signed source operand and a yield mask. From the sign and value of the source, the unit picks one of three outcomes:

- The caller deactivates itself.
- A thread fault is raised with a cause code that names the reason.
- Nothing changes, and the unit only returns the masked reschedule condition.

The unit sees a small table of context state. For every hardware context it sees the binding (processing-element number and context number), the allocatable flag, the halt flag and the activated flag. It also gets the caller's own binding, the index of the last configured context, the caller's dirty flag and the enable for scheduler interrupts on yield.

A request is a one-cycle strobe on `req_valid`. All decisions appear on registered outputs on the following clock edge. When the unit raises the status strobe, the status logic outside the block clears the caller's activated bit. Scheduling and suspension of threads are done elsewhere.

Top module: `yield_decide`

## Requirements
- R1: After a synchronous reset, `done`, `deact_wr` and `fault` are 0, `exc_cause` is 0 and `result` is 0.
- R2: Each request gives, one clock later, a one-cycle `done` pulse with `result` equal to the bitwise AND of the source and the mask. With no request, `done` is 0.
- R3: A zero source raises `deact_wr` for one cycle when one qualifying context exists. That context must be configured, bound to the caller's element and context number, allocatable, not halted and activated. No fault is raised.
- R4: A zero source raises neither `deact_wr` nor `fault` if the caller's matching context is missing, halted, not allocatable or not activated.
- R5: A context whose index is greater than `cfg_last_ctx` never qualifies under R3.
- R6: A positive source with any bit set where the mask is 0 raises `fault` with `exc_cause` = 2 (3-bit code).
- R7: A positive source that lies wholly inside the mask raises neither `fault` nor `deact_wr`.
- R8: A negative source other than -2 raises `fault` with `exc_cause` = 4 when `sched_int_en` and `caller_dirty` are both 1. Otherwise it raises no fault.
- R9: A source of exactly -2 raises neither `fault` nor `deact_wr`, whatever the enable and dirty inputs are.
- R10: Whenever `fault` is 0, `exc_cause` is 0, and `fault` and `deact_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| src_val | input | DATA_W | Signed source operand |
| yield_mask | input | DATA_W | Yield mask |
| caller_elem | input | ELEM_W | Caller's bound processing element |
| caller_slot | input | CTX_W | Caller's context number |
| caller_dirty | input | 1 | Caller's dirty flag |
| sched_int_en | input | 1 | Scheduler-interrupt-on-yield enable |
| cfg_last_ctx | input | CTX_W | Index of the last configured context |
| ctx_elem_flat | input | NCTX*ELEM_W | Element binding of each context |
| ctx_slot_flat | input | NCTX*CTX_W | Context-number binding of each context |
| ctx_alloc | input | NCTX | Allocatable flag per context |
| ctx_halt | input | NCTX | Halt flag per context |
| ctx_active | input | NCTX | Activated flag per context |
| done | output | 1 | Decision pulse |
| result | output | DATA_W | Source AND mask |
| deact_wr | output | 1 | Strobe to clear the caller's activated bit |
| fault | output | 1 | Thread fault pulse |
| exc_cause | output | 3 | Exception cause code (2 or 4 while fault) |

## Verification
The tests cover each source class: zero, positive inside the mask, positive outside the mask, -2, and other negatives.

The zero source is repeated with one qualifying flag removed per run: halt set, allocatable cleared, activated cleared, wrong element, and index beyond the configured count. This shows that each condition gates deactivation on its own.

The other negatives are tried under all four combinations of enable and dirty. This separates the cause-4 fault from the silent path. The -2 source is driven with both inputs high, to show it escapes that fault. Idle cycles between requests check that the outputs return to zero.

// File: rtl/yield_pkg.sv
package yield_pkg;
  localparam int CAUSE_W = 3;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE      = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_MASK_VIOL = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_YIELD_INT = 3'd4;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_POS,
    SRC_SKIP,
    SRC_NEG
  } src_class_e;
endpackage

// File: rtl/yield_ctx_match.sv
module yield_ctx_match #(
  parameter int NCTX   = 8,
  parameter int ELEM_W = 2,
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic [ELEM_W-1:0]      caller_elem,
  input  logic [CTX_W-1:0]       caller_slot,
  input  logic [CTX_W-1:0]       cfg_last_ctx,
  input  logic [NCTX*ELEM_W-1:0] ctx_elem_flat,
  input  logic [NCTX*CTX_W-1:0]  ctx_slot_flat,
  input  logic [NCTX-1:0]        ctx_alloc,
  input  logic [NCTX-1:0]        ctx_halt,
  input  logic [NCTX-1:0]        ctx_active,
  output logic                   any_hit
);
  logic [NCTX-1:0] hit;

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    logic in_range, bound;
    assign in_range = (CTX_W'(i) <= cfg_last_ctx);
    assign bound    = (ctx_elem_flat[i*ELEM_W +: ELEM_W] == caller_elem) &&
                      (ctx_slot_flat[i*CTX_W +: CTX_W] == caller_slot);
    assign hit[i]   = in_range && bound && ctx_alloc[i] && !ctx_halt[i] && ctx_active[i];
  end

  assign any_hit = |hit;
endmodule

// File: rtl/yield_classify.sv
module yield_classify
  import yield_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] yield_mask,
  output src_class_e        cls,
  output logic              outside_mask
);
  localparam logic [DATA_W-1:0] MINUS_TWO = ~DATA_W'(1);

  always_comb begin
    if (src_val == '0)                cls = SRC_ZERO;
    else if (!src_val[DATA_W-1])      cls = SRC_POS;
    else if (src_val == MINUS_TWO)    cls = SRC_SKIP;
    else                              cls = SRC_NEG;
  end

  assign outside_mask = |(src_val & ~yield_mask);
endmodule

// File: rtl/yield_decide.sv
module yield_decide
  import yield_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCTX   = 8,
  parameter int ELEM_W = 2,
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [DATA_W-1:0]      src_val,
  input  logic [DATA_W-1:0]      yield_mask,
  input  logic [ELEM_W-1:0]      caller_elem,
  input  logic [CTX_W-1:0]       caller_slot,
  input  logic                   caller_dirty,
  input  logic                   sched_int_en,
  input  logic [CTX_W-1:0]       cfg_last_ctx,
  input  logic [NCTX*ELEM_W-1:0] ctx_elem_flat,
  input  logic [NCTX*CTX_W-1:0]  ctx_slot_flat,
  input  logic [NCTX-1:0]        ctx_alloc,
  input  logic [NCTX-1:0]        ctx_halt,
  input  logic [NCTX-1:0]        ctx_active,
  output logic                   done,
  output logic [DATA_W-1:0]      result,
  output logic                   deact_wr,
  output logic                   fault,
  output logic [CAUSE_W-1:0]     exc_cause
);
  logic       any_hit;
  logic       outside_mask;
  src_class_e cls;

  yield_ctx_match #(.NCTX(NCTX), .ELEM_W(ELEM_W)) u_match (
    .caller_elem  (caller_elem),
    .caller_slot  (caller_slot),
    .cfg_last_ctx (cfg_last_ctx),
    .ctx_elem_flat(ctx_elem_flat),
    .ctx_slot_flat(ctx_slot_flat),
    .ctx_alloc    (ctx_alloc),
    .ctx_halt     (ctx_halt),
    .ctx_active   (ctx_active),
    .any_hit      (any_hit)
  );

  yield_classify #(.DATA_W(DATA_W)) u_cls (
    .src_val     (src_val),
    .yield_mask  (yield_mask),
    .cls         (cls),
    .outside_mask(outside_mask)
  );

  logic               deact_n, fault_n;
  logic [CAUSE_W-1:0] cause_n;

  always_comb begin
    deact_n = 1'b0;
    fault_n = 1'b0;
    cause_n = CAUSE_NONE;
    if (req_valid) begin
      unique case (cls)
        SRC_ZERO: deact_n = any_hit;
        SRC_POS: if (outside_mask) begin
          fault_n = 1'b1;
          cause_n = CAUSE_MASK_VIOL;
        end
        SRC_NEG: if (sched_int_en && caller_dirty) begin
          fault_n = 1'b1;
          cause_n = CAUSE_YIELD_INT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      result    <= '0;
      deact_wr  <= 1'b0;
      fault     <= 1'b0;
      exc_cause <= CAUSE_NONE;
    end else begin
      done      <= req_valid;
      deact_wr  <= deact_n;
      fault     <= fault_n;
      exc_cause <= cause_n;
      if (req_valid) result <= src_val & yield_mask;
    end
  end

  assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done && result == $past(src_val & yield_mask));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done && !fault && !deact_wr);
  assert_skip_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && src_val == ~DATA_W'(1)) |=> !fault && !deact_wr);
  assert_cause_legal_R10: assert property (@(posedge clk) disable iff (rst)
    fault |-> (exc_cause == CAUSE_MASK_VIOL || exc_cause == CAUSE_YIELD_INT));
  assert_cause_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !fault |-> exc_cause == CAUSE_NONE);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(fault && deact_wr));
  assert_neg_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && src_val[DATA_W-1] && !(sched_int_en && caller_dirty)) |=> !fault);
endmodule

// File: tb/yield_decide_tb.sv
module yield_decide_tb;
  localparam int DATA_W = 32, NCTX = 8, ELEM_W = 2, CTX_W = 3;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic                   req_valid = 0;
  logic [DATA_W-1:0]      src_val = 0, yield_mask = 0;
  logic [ELEM_W-1:0]      caller_elem = 2'd1;
  logic [CTX_W-1:0]       caller_slot = 3'd5;
  logic                   caller_dirty = 0, sched_int_en = 0;
  logic [CTX_W-1:0]       cfg_last_ctx = 3'd7;
  logic [NCTX*ELEM_W-1:0] ctx_elem_flat;
  logic [NCTX*CTX_W-1:0]  ctx_slot_flat;
  logic [NCTX-1:0]        ctx_alloc, ctx_halt, ctx_active;
  logic                   done, deact_wr, fault;
  logic [DATA_W-1:0]      result;
  logic [2:0]             exc_cause;

  int n_tests = 0, n_fail = 0;

  yield_decide #(.DATA_W(DATA_W), .NCTX(NCTX), .ELEM_W(ELEM_W)) u_dut (.*);

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic table_default();
    for (int i = 0; i < NCTX; i++) begin
      ctx_elem_flat[i*ELEM_W +: ELEM_W] = ELEM_W'(i % 4);
      ctx_slot_flat[i*CTX_W +: CTX_W]   = CTX_W'(i);
    end
    ctx_alloc = 8'h20; ctx_halt = 8'h00; ctx_active = 8'h20;
    caller_elem = 2'd1; caller_slot = 3'd5; cfg_last_ctx = 3'd7;
  endtask

  // one request, outputs sampled at the following falling edge
  task automatic issue(logic [DATA_W-1:0] s, logic [DATA_W-1:0] m);
    @(negedge clk);
    src_val = s; yield_mask = m; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_out(string req, logic d, logic f, logic [2:0] c, logic [DATA_W-1:0] r);
    chk({req, " done"}, DATA_W'(done), DATA_W'(1'b1));
    chk({req, " deact"}, DATA_W'(deact_wr), DATA_W'(d));
    chk({req, " fault"}, DATA_W'(fault), DATA_W'(f));
    chk({req, " cause"}, DATA_W'(exc_cause), DATA_W'(c));
    chk({req, " result"}, result, r);
  endtask

  task automatic t_reset();
    chk("R1 done", DATA_W'(done), 0); chk("R1 fault", DATA_W'(fault), 0);
    chk("R1 deact", DATA_W'(deact_wr), 0); chk("R1 cause", DATA_W'(exc_cause), 0);
    chk("R1 result", result, 0);
  endtask

  task automatic t_deact();
    table_default();
    issue(0, 32'hFFFF); expect_out("R3 zero match", 1, 0, 0, 0);
    @(negedge clk);
    chk("R2 idle done", DATA_W'(done), 0); chk("R2 idle deact", DATA_W'(deact_wr), 0);
  endtask

  task automatic t_nomatch();
    table_default(); ctx_halt[5] = 1;   issue(0, 1); expect_out("R4 halted", 0, 0, 0, 0);
    table_default(); ctx_alloc[5] = 0;  issue(0, 1); expect_out("R4 not alloc", 0, 0, 0, 0);
    table_default(); ctx_active[5] = 0; issue(0, 1); expect_out("R4 inactive", 0, 0, 0, 0);
    table_default(); caller_elem = 2'd2; issue(0, 1); expect_out("R4 wrong elem", 0, 0, 0, 0);
    table_default(); cfg_last_ctx = 3'd4; issue(0, 1); expect_out("R5 beyond count", 0, 0, 0, 0);
    table_default(); cfg_last_ctx = 3'd5; issue(0, 1); expect_out("R5 at last", 1, 0, 0, 0);
  endtask

  task automatic t_positive();
    table_default();
    issue(32'h0000_0130, 32'h0000_00F0); expect_out("R6 outside", 0, 1, 3'd2, 32'h30);
    issue(32'h0000_0030, 32'h0000_00F0); expect_out("R7 inside", 0, 0, 0, 32'h30);
    issue(32'h7FFF_FFFF, 32'hFFFF_FFFF); expect_out("R7 full mask", 0, 0, 0, 32'h7FFF_FFFF);
  endtask

  task automatic t_negative();
    table_default();
    for (int k = 0; k < 4; k++) begin
      sched_int_en = k[0]; caller_dirty = k[1];
      issue(32'hFFFF_FFFF, 32'h0000_000F);
      expect_out("R8 neg", 0, k == 3, (k == 3) ? 3'd4 : 3'd0, 32'hF);
    end
    issue(32'h8000_0000, 32'h8000_0001); expect_out("R8 min", 0, 1, 3'd4, 32'h8000_0000);
    issue(32'hFFFF_FFFE, 32'h0000_00FF); expect_out("R9 minus two", 0, 0, 0, 32'hFE);
    @(negedge clk);
    chk("R10 idle cause", DATA_W'(exc_cause), 0); chk("R10 idle fault", DATA_W'(fault), 0);
    sched_int_en = 0; caller_dirty = 0;
  endtask

  initial begin
    table_default();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_deact();
    t_nomatch();
    t_positive();
    t_negative();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule